// File: doc/BRIEF.md
# Triple-Mode Digital Phase Comparator

This block measures the phase error between a reference input and a feedback input. It runs on a system clock that is much faster than either input. Both inputs pass through a shared front end that synchronizes them and detects their rising edges. That front end feeds three detectors, which all run in parallel.

- **Level-difference detector.** It gives the exclusive-OR of the two sampled input levels.
- **Edge-driven charge-pump detector.** It is modelled as a drive level plus a drive enable. A lock flag goes high while the pump is released.
- **Set/clear flip-flop detector.** It is set by reference edges and cleared by feedback edges.

A registered 2-bit selector routes one of the three detectors to a single loop-drive output, which feeds an external loop filter.

The pump detector is a state machine with three states:

- `PUMP_FLOAT`: released, high impedance.
- `PUMP_UP`: driving high.
- `PUMP_DOWN`: driving low.

Its transitions are:

- `FLOAT->UP`: a reference edge arrives alone.
- `FLOAT->DOWN`: a feedback edge arrives alone.
- `UP->FLOAT`: a feedback edge arrives, alone or together with a reference edge.
- `DOWN->FLOAT`: a reference edge arrives, alone or together with a feedback edge.
- `UP->UP`: a further reference edge arrives alone.
- `DOWN->DOWN`: a further feedback edge arrives alone.
- `FLOAT->FLOAT`: both edges arrive together, or no edge arrives.

Top module: `triple_phase_detector`

## Requirements
- R1: `xor_out` is the XOR of the two synchronized input levels. With inputs in phase it stays 0. With inputs 180 degrees apart it stays 1.
- R2: Each input passes through two synchronizer flops and an edge register. Every detector output changes on the third rising clock edge after the input changes, and not before. Only rising edges act on the pump and the set/clear detectors. Input falling edges and pulse width have no effect on them.
- R3: A reference edge seen while `PUMP_FLOAT` enters `PUMP_UP`, so `pump_en`=1 and `pump_level`=1. The next feedback edge returns the pump to `PUMP_FLOAT`, so `pump_en`=0.
- R4: A feedback edge seen while `PUMP_FLOAT` enters `PUMP_DOWN`, so `pump_en`=1 and `pump_level`=0. The next reference edge returns the pump to `PUMP_FLOAT`.
- R5: `lock_pulse` is 1 exactly when `pump_en` is 0.
- R6: While only feedback edges occur, the pump stays in `PUMP_DOWN`.
- R7: Any reference pulse, even one clock wide, counts as an edge. Further reference edges while in `PUMP_UP` keep the pump driving high until a feedback edge arrives, however long that takes.
- R8: A lone reference edge sets `rs_out` to 1. A lone feedback edge clears it to 0.
- R9: When both edges are detected in the same clock, the pump goes to or stays in `PUMP_FLOAT`, and `rs_out` keeps its value.
- R10: A synchronous active-high `rst` has these effects:
  - The pump goes to `PUMP_FLOAT`, so `lock_pulse`=1 and `pump_en`=0.
  - `rs_out` and `xor_out` go to 0.
  - The selector returns to code 00.
- R11: `mode_sel` is registered, so `loop_drive` follows a new code one clock later. The codes are:
  - 00: `xor_out`.
  - 01: `pump_level & pump_en`, so a released pump reads 0.
  - 10: `rs_out`.
  - 11: `xor_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference input |
| fb_in | input | 1 | Asynchronous feedback input |
| mode_sel | input | 2 | Loop-drive source code |
| xor_out | output | 1 | Level-difference detector output |
| pump_level | output | 1 | Pump drive level, valid while enabled |
| pump_en | output | 1 | Pump drive enable (0 = high impedance) |
| lock_pulse | output | 1 | High while the pump is released |
| rs_out | output | 1 | Set/clear detector output |
| loop_drive | output | 1 | Selected detector output |

## Verification
Every detector output is due on the third rising clock edge after an input change. `loop_drive` follows a new `mode_sel` one clock later. The bench drives inputs on falling clock edges and waits an exact number of falling edges before sampling. For the edge-driven detectors it also samples one edge early to confirm that nothing has moved yet. Steady-state checks, such as the XOR phase sweep and the pump holding across a long gap, begin only once the three-edge latency from the last input change has elapsed.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic [1:0] {
        PUMP_FLOAT = 2'b00,
        PUMP_UP    = 2'b01,
        PUMP_DOWN  = 2'b10
    } pump_state_t;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_XOR   = 2'b00,
        SEL_PUMP  = 2'b01,
        SEL_RS    = 2'b10,
        SEL_SPARE = 2'b11
    } drive_sel_t;

endpackage

// File: rtl/tpd_edge_front.sv
module tpd_edge_front #(
    parameter int SYNC_STAGES = 2,
    parameter int CHANNELS    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] raw_in,
    output logic [CHANNELS-1:0] level,
    output logic [CHANNELS-1:0] rise
);

    localparam int LAST = SYNC_STAGES - 1;

    generate
        for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
            logic [SYNC_STAGES-1:0] chain_q;
            logic                   prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '0;
                    prev_q  <= 1'b0;
                end else begin
                    chain_q <= {chain_q[SYNC_STAGES-2:0], raw_in[c]};
                    prev_q  <= chain_q[LAST];
                end
            end

            assign level[c] = chain_q[LAST];
            assign rise[c]  = chain_q[LAST] & ~prev_q;

            // R2
            rise_single_chk: assert property (@(posedge clk) disable iff (rst)
                rise[c] |=> !rise[c])
                else $error("rise pulse longer than one clock");
        end
    endgenerate

endmodule

// File: rtl/tpd_pump_fsm.sv
module tpd_pump_fsm
    import tpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic pump_level,
    output logic pump_en,
    output logic lock_pulse
);

    pump_state_t state_q;
    pump_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PUMP_FLOAT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PUMP_FLOAT: begin
                if (ref_rise && !fb_rise)      state_d = PUMP_UP;
                else if (fb_rise && !ref_rise) state_d = PUMP_DOWN;
            end
            PUMP_UP: begin
                if (fb_rise) state_d = PUMP_FLOAT;
            end
            PUMP_DOWN: begin
                if (ref_rise) state_d = PUMP_FLOAT;
            end
            default: state_d = PUMP_FLOAT;
        endcase
    end

    always_comb begin
        pump_level = 1'b0;
        pump_en    = 1'b0;
        lock_pulse = 1'b1;
        unique case (state_q)
            PUMP_FLOAT: begin
                pump_level = 1'b0;
                pump_en    = 1'b0;
                lock_pulse = 1'b1;
            end
            PUMP_UP: begin
                pump_level = 1'b1;
                pump_en    = 1'b1;
                lock_pulse = 1'b0;
            end
            PUMP_DOWN: begin
                pump_level = 1'b0;
                pump_en    = 1'b1;
                lock_pulse = 1'b0;
            end
            default: begin
                pump_level = 1'b0;
                pump_en    = 1'b0;
                lock_pulse = 1'b1;
            end
        endcase
    end

    // R3
    pump_up_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PUMP_FLOAT && ref_rise && !fb_rise) |=> (pump_en && pump_level))
        else $error("reference edge did not start the up pump");

    // R3
    pump_up_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PUMP_UP && fb_rise) |=> (!pump_en && lock_pulse))
        else $error("feedback edge did not release the up pump");

    // R4
    pump_down_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PUMP_FLOAT && fb_rise && !ref_rise) |=> (pump_en && !pump_level))
        else $error("feedback edge did not start the down pump");

    // R6
    pump_down_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PUMP_DOWN && !ref_rise) |=> (pump_en && !pump_level))
        else $error("down pump left without a reference edge");

    // R7
    pump_up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PUMP_UP && !fb_rise) |=> (pump_en && pump_level))
        else $error("up pump left without a feedback edge");

    // R9
    pump_both_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise) |=> lock_pulse)
        else $error("coincident edges left the pump driving");

    // R10
    pump_reset_chk: assert property (@(posedge clk)
        rst |=> (lock_pulse && !pump_en))
        else $error("reset did not release the pump");

endmodule

// File: rtl/tpd_rs_flop.sv
module tpd_rs_flop (
    input  logic clk,
    input  logic rst,
    input  logic set_rise,
    input  logic clr_rise,
    output logic rs_q
);

    always_ff @(posedge clk) begin
        if (rst)                        rs_q <= 1'b0;
        else if (set_rise && !clr_rise) rs_q <= 1'b1;
        else if (clr_rise && !set_rise) rs_q <= 1'b0;
    end

    // R8
    rs_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_rise && !clr_rise) |=> rs_q)
        else $error("set edge ignored");

    // R8
    rs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_rise && !set_rise) |=> !rs_q)
        else $error("clear edge ignored");

    // R9
    rs_tie_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_rise && clr_rise) |=> $stable(rs_q))
        else $error("coincident edges changed the flop");

    // R10
    rs_reset_chk: assert property (@(posedge clk)
        rst |=> !rs_q)
        else $error("reset did not clear the flop");

endmodule

// File: rtl/triple_phase_detector.sv
module triple_phase_detector
    import tpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [SEL_W-1:0] mode_sel,
    output logic             xor_out,
    output logic             pump_level,
    output logic             pump_en,
    output logic             lock_pulse,
    output logic             rs_out,
    output logic             loop_drive
);

    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;

    logic [1:0] lvl;
    logic [1:0] rise;
    logic       xor_q;
    drive_sel_t sel_q;

    tpd_edge_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .CHANNELS   (2)
    ) u_front (
        .clk   (clk),
        .rst   (rst),
        .raw_in({fb_in, ref_in}),
        .level (lvl),
        .rise  (rise)
    );

    tpd_pump_fsm u_pump (
        .clk       (clk),
        .rst       (rst),
        .ref_rise  (rise[CH_REF]),
        .fb_rise   (rise[CH_FB]),
        .pump_level(pump_level),
        .pump_en   (pump_en),
        .lock_pulse(lock_pulse)
    );

    tpd_rs_flop u_rs (
        .clk     (clk),
        .rst     (rst),
        .set_rise(rise[CH_REF]),
        .clr_rise(rise[CH_FB]),
        .rs_q    (rs_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xor_q <= 1'b0;
            sel_q <= SEL_XOR;
        end else begin
            xor_q <= lvl[CH_REF] ^ lvl[CH_FB];
            sel_q <= drive_sel_t'(mode_sel);
        end
    end

    assign xor_out = xor_q;

    always_comb begin
        unique case (sel_q)
            SEL_XOR:   loop_drive = xor_q;
            SEL_PUMP:  loop_drive = pump_level & pump_en;
            SEL_RS:    loop_drive = rs_out;
            SEL_SPARE: loop_drive = xor_q;
            default:   loop_drive = xor_q;
        endcase
    end

    // R11
    drive_rs_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_sel) == 2'b10) |-> (loop_drive == rs_out))
        else $error("selector code 10 did not route the set/clear output");

    // R11
    drive_pump_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_sel) == 2'b01 && lock_pulse) |-> !loop_drive)
        else $error("released pump did not read as 0");

    // R5
    lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        lock_pulse != pump_en)
        else $error("lock flag disagrees with pump enable");

endmodule

// File: tb/test_triple_phase_detector.sv
module test_triple_phase_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       xor_out, pump_level, pump_en, lock_pulse, rs_out, loop_drive;

    int tests_run = 0;
    int tests_failed = 0;

    always #5 clk = ~clk;

    triple_phase_detector i_triple_phase_detector (
        .clk       (clk),
        .rst       (rst),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .mode_sel  (mode_sel),
        .xor_out   (xor_out),
        .pump_level(pump_level),
        .pump_en   (pump_en),
        .lock_pulse(lock_pulse),
        .rs_out    (rs_out),
        .loop_drive(loop_drive)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0; mode_sel = 2'b00;
        wt(2);
        rst = 1'b0;
    endtask

    // R10: state while reset is held
    task automatic t_reset();
        rst = 1'b1;
        wt(3);
        chk("R10", "lock_pulse", lock_pulse, 1'b1);
        chk("R10", "pump_en", pump_en, 1'b0);
        chk("R10", "rs_out", rs_out, 1'b0);
        chk("R10", "xor_out", xor_out, 1'b0);
        chk("R10", "loop_drive", loop_drive, 1'b0);
        rst = 1'b0;
    endtask

    // R3, R2, R5, R8: reference leads
    task automatic t_ref_lead();
        ref_in = 1'b1;
        wt(2);
        chk("R2", "pump_en early", pump_en, 1'b0);
        chk("R2", "rs_out early", rs_out, 1'b0);
        wt(1);
        chk("R3", "pump_en", pump_en, 1'b1);
        chk("R3", "pump_level", pump_level, 1'b1);
        chk("R5", "lock_pulse", lock_pulse, 1'b0);
        chk("R8", "rs set", rs_out, 1'b1);
        chk("R1", "xor ref only", xor_out, 1'b1);
        ref_in = 1'b0;
        wt(3);
        chk("R2", "falling ref ignored", pump_en, 1'b1);
        chk("R1", "xor both low", xor_out, 1'b0);
        fb_in = 1'b1;
        wt(2);
        chk("R2", "release early", pump_en, 1'b1);
        wt(1);
        chk("R3", "released", pump_en, 1'b0);
        chk("R5", "lock after release", lock_pulse, 1'b1);
        chk("R8", "rs cleared", rs_out, 1'b0);
        fb_in = 1'b0;
        wt(3);
    endtask

    // R4, R8: feedback leads
    task automatic t_fb_lead();
        fb_in = 1'b1;
        wt(3);
        chk("R4", "pump_en", pump_en, 1'b1);
        chk("R4", "pump_level", pump_level, 1'b0);
        chk("R5", "lock low", lock_pulse, 1'b0);
        fb_in = 1'b0;
        wt(2);
        ref_in = 1'b1;
        wt(3);
        chk("R4", "released", pump_en, 1'b0);
        chk("R8", "rs set", rs_out, 1'b1);
        ref_in = 1'b0;
        wt(3);
    endtask

    // R6: feedback edges only
    task automatic t_fb_only();
        for (int k = 0; k < 3; k++) begin
            fb_in = 1'b1;
            wt(3);
            chk("R6", "pump_en", pump_en, 1'b1);
            chk("R6", "pump_level", pump_level, 1'b0);
            fb_in = 1'b0;
            wt(3);
            chk("R6", "still down", pump_en, 1'b1);
        end
        ref_in = 1'b1;
        wt(3);
        chk("R4", "released", lock_pulse, 1'b1);
        ref_in = 1'b0;
        wt(3);
    endtask

    // R7: one-clock reference pulses
    task automatic t_spurious();
        ref_in = 1'b1;
        wt(1);
        ref_in = 1'b0;
        wt(2);
        chk("R7", "narrow pulse up", pump_en & pump_level, 1'b1);
        wt(20);
        chk("R7", "holds through gap", pump_en & pump_level, 1'b1);
        ref_in = 1'b1;
        wt(1);
        ref_in = 1'b0;
        wt(2);
        chk("R7", "second pulse holds", pump_en & pump_level, 1'b1);
        fb_in = 1'b1;
        wt(3);
        chk("R7", "fb releases", pump_en, 1'b0);
        chk("R8", "rs cleared", rs_out, 1'b0);
        fb_in = 1'b0;
        wt(3);
    endtask

    // R9: coincident edges
    task automatic t_simul();
        ref_in = 1'b1; fb_in = 1'b1;
        wt(3);
        chk("R9", "float stays float", lock_pulse, 1'b1);
        chk("R9", "rs holds 0", rs_out, 1'b0);
        ref_in = 1'b0; fb_in = 1'b0;
        wt(3);
        ref_in = 1'b1;
        wt(3);
        chk("R3", "up again", pump_en & pump_level, 1'b1);
        ref_in = 1'b0;
        wt(3);
        ref_in = 1'b1; fb_in = 1'b1;
        wt(3);
        chk("R9", "up to float", lock_pulse, 1'b1);
        chk("R9", "rs holds 1", rs_out, 1'b1);
        ref_in = 1'b0; fb_in = 1'b0;
        wt(3);
    endtask

    // R1: phase sweep of the XOR detector
    task automatic t_phase();
        int bad_in = 0;
        int bad_anti = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ref_in = ((i % 8) < 4);
            fb_in  = ((i % 8) < 4);
            if (xor_out !== 1'b0) bad_in++;
        end
        ref_in = 1'b0; fb_in = 1'b0;
        wt(4);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ref_in = ((i % 8) < 4);
            fb_in  = !((i % 8) < 4);
            if (i >= 3 && xor_out !== 1'b1) bad_anti++;
        end
        chk("R1", "in phase low", bad_in == 0, 1'b1);
        chk("R1", "anti phase high", bad_anti == 0, 1'b1);
        ref_in = 1'b0; fb_in = 1'b0;
        wt(4);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_sel = m;
        wt(1);
    endtask

    // R11: selector routing
    task automatic t_mode();
        do_reset();
        fb_in = 1'b1;
        wt(3);
        chk("R11", "00 xor=1", loop_drive, 1'b1);
        set_mode(2'b01); chk("R11", "01 pump down", loop_drive, 1'b0);
        set_mode(2'b10); chk("R11", "10 rs=0", loop_drive, 1'b0);
        set_mode(2'b11); chk("R11", "11 xor=1", loop_drive, 1'b1);
        ref_in = 1'b1;
        wt(3);
        chk("R11", "11 xor=0", loop_drive, 1'b0);
        set_mode(2'b10); chk("R11", "10 rs=1", loop_drive, 1'b1);
        set_mode(2'b01); chk("R11", "01 released", loop_drive, 1'b0);
        ref_in = 1'b0; fb_in = 1'b0;
        wt(3);
        ref_in = 1'b1;
        wt(3);
        ref_in = 1'b0;
        wt(3);
        chk("R11", "01 pump up", loop_drive, 1'b1);
        set_mode(2'b00); chk("R11", "00 xor=0", loop_drive, 1'b0);
    endtask

    initial begin
        t_reset();
        t_ref_lead();
        t_fb_lead();
        t_fb_only();
        t_spurious();
        t_simul();
        t_phase();
        t_mode();
        do_reset();
        wt(1);
        chk("R10", "lock after reset", lock_pulse, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #1_000_000;
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule